// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a small register bus. The bus has an address, a read strobe, a write strobe, write data and registered read data. A direction register sets each pin as an output or as an input.

Output pins are driven from a shared data register. Input pins copy their synchronized external level into the same register. The data register is seen through a 1 KB address window. The word-address bits inside that window act as a per-pin mask. Software can therefore set, clear or sample any subset of pins in one access, with no read-modify-write. A fixed block of identification bytes sits at the top of the 4 KB space.

Read requests return data on the clock after the request. Each external pin passes through a two-flop synchronizer before it reaches the data register.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is asserted and just after it, the data register, the direction register and `rdata_o` are all zero. As a result, `pin_oe_o` and `pin_o` are zero.
- R2: A read at any byte offset from 0x000 to 0x3FF returns the data register ANDed with address bits [9:2], in bits [7:0]. All other bits read as 0.
- R3: A write in the data window changes only the data bits whose bit is set both in address bits [9:2] and in the direction register. Those bits take the matching bit of `wdata_i[7:0]`. Every other bit keeps its value.
- R4: The direction register is at offset 0x400 and takes `wdata_i[7:0]`. It reads back in `rdata_o[7:0]`. A 1 makes the pin an output. `pin_oe_o` equals the direction register, and `pin_o` equals the data register ANDed with the direction register.
- R5: For a pin configured as an input (direction bit 0), the data bit takes the level of `pin_i` through a two-stage synchronizer. A change on `pin_i` is readable no earlier than the third rising edge after it. For pins configured as outputs, `pin_i` has no effect.
- R6: Word k (k = 0 to 11) of the region 0xFD0 to 0xFFF reads the identification byte in bits [7:0]. The bytes in order are 0x00, 0x00, 0x00, 0x00, 0x61, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Bits [31:8] read as 0.
- R7: Reads of any other offset return 0. Writes to any offset other than the data window and 0x400 change no state.
- R8: `rdata_o` is loaded on the rising edge where `rd_i` is high. It holds its value while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte address; bits [1:0] are ignored |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data; bits [7:0] are used |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 8 | External pin levels (asynchronous) |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables (direction) |

## Verification
The assertions compare each register with its value one cycle earlier. This holds only if `addr_i`, `wr_i`, `rd_i` and `wdata_i` are free of X after reset. The stimulus meets this by driving every bus input from time zero and changing them only on falling edges.

The input-tracking property samples the synchronizer output rather than the raw pin. It therefore says nothing about metastability. The stimulus only changes `pin_i` on a falling edge, then waits more than three edges before it expects the new level. The masked-write property covers only pins that were outputs in the previous cycle. For this reason the sweeps hold the direction register fixed while they walk every address mask.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int ID_COUNT = 12;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd4:    return 8'h61;
      4'd5:    return 8'h10;
      4'd6:    return 8'h04;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         data_we_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] data_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= '0;
    else if (dir_we_i) dir_q <= wdata_i;
  end

  // inputs track the synchronizer; outputs take masked bus writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (!dir_q[i])                   data_q[i] <= sync_i[i];
        else if (data_we_i && mask_i[i]) data_q[i] <= wdata_i[i];
      end
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_we_i |=> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0)); // R3
  AST_OUT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(mask_i)) == '0)); // R3
  AST_DIR_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> (dir_q == $past(wdata_i))); // R4
  AST_IN_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_we_i |=> ((data_q & ~dir_q) == ($past(sync_i) & ~dir_q))); // R5
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_mask_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-3:0] word_i,
  input  logic [W-1:0]  data_i,
  input  logic [W-1:0]  dir_i,
  output logic [DW-1:0] rdata_o
);
  localparam int            WW      = AW - 2;
  localparam logic [WW-1:0] DIR_WORD = WW'(1 << W);
  localparam logic [WW-1:0] ID_BASE  = WW'((1 << WW) - ID_COUNT);

  logic          in_data, in_dir, in_id;
  logic [WW-1:0] id_off;
  logic [W-1:0]  rd_val;
  logic [DW-1:0] rdata_q;

  assign in_data = (word_i[WW-1:W] == '0);
  assign in_dir  = (word_i == DIR_WORD);
  assign in_id   = (word_i >= ID_BASE);
  assign id_off  = word_i - ID_BASE;

  always_comb begin
    rd_val = '0;
    if (in_data)     rd_val = data_i & word_i[W-1:0];
    else if (in_dir) rd_val = dir_i;
    else if (in_id)  rd_val = W'(id_byte(id_off[3:0]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= DW'(rd_val);
  end

  assign rdata_o = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !in_data && !in_dir && !in_id) |=> (rdata_q == '0)); // R7
  AST_DATA_RD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_data) |=> ((rdata_q & ~DW'($past(word_i[W-1:0]))) == '0)); // R2
  AST_ID_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_id) |=> (rdata_q[DW-1:8] == '0)); // R6
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int NPINS       = 8,
  parameter int AW          = 12,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o
);
  localparam int            WW       = AW - 2;
  localparam logic [WW-1:0] DIR_WORD = WW'(1 << NPINS);

  logic [WW-1:0]    word;
  logic [NPINS-1:0] sync_pins, data, dir;
  logic             data_we, dir_we;
  logic             unused_bits;

  assign word        = addr_i[AW-1:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:NPINS]};
  assign data_we     = wr_i && (word[WW-1:NPINS] == '0);
  assign dir_we      = wr_i && (word == DIR_WORD);

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_pins)
  );

  gpio_data_reg #(.W(NPINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_we_i(data_we),
    .dir_we_i (dir_we),
    .mask_i   (word[NPINS-1:0]),
    .wdata_i  (wdata_i[NPINS-1:0]),
    .sync_i   (sync_pins),
    .data_o   (data),
    .dir_o    (dir)
  );

  gpio_rd_port #(.W(NPINS), .AW(AW), .DW(DW)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .word_i (word),
    .data_i (data),
    .dir_i  (dir),
    .rdata_o(rdata_o)
  );

  assign pin_oe_o = dir;
  assign pin_o    = data & dir;

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pin_oe_o == '0 && rdata_o == '0)); // R1
  AST_PIN_OUT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o & ~pin_oe_o) == '0)); // R4
endmodule

// File: tb/tb_gpio_mask_port.sv
module tb_gpio_mask_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] addr = '0;
  logic        rd = 0, wr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pin = 8'hC3;
  logic [7:0]  pout, poe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_mask_port dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pout), .pin_oe_o(poe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks are entered and left on a falling edge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    addr = a; rd = 1;
    @(posedge clk); @(negedge clk);
    rd = 0;
    d = rdata;
  endtask

  function automatic logic [7:0] id_exp(input int k);
    case (k)
      4: return 8'h61; 5: return 8'h10; 6: return 8'h04;
      8: return 8'h0D; 9: return 8'hF0; 10: return 8'h05; 11: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    logic [31:0] r;
    logic [7:0]  model, dirv, held;
    repeat (3) @(negedge clk);
    check("R1 rdata", rdata, 0);
    check("R1 oe", {24'b0, poe}, 0);
    check("R1 pin_o", {24'b0, pout}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 oe after", {24'b0, poe}, 0);
    bus_read(12'h3FC, r);
    check("R5 inputs loaded", r, 32'hC3);

    dirv = 8'h5A;
    bus_write(12'h400, {24'hFFFFFF, dirv});
    bus_read(12'h400, r);
    check("R4 dir readback", r, {24'b0, dirv});
    check("R4 oe", {24'b0, poe}, {24'b0, dirv});
    model = 8'hC3;
    check("R4 pin_o", {24'b0, pout}, {24'b0, model & dirv});

    for (int m = 0; m < 256; m++) begin
      logic [7:0] v, rm;
      v  = 8'(m * 37) ^ 8'hA5;
      rm = 8'(m) ^ 8'h3C;
      bus_write(12'(m << 2), {24'b0, v});
      model = (model & ~(8'(m) & dirv)) | (v & 8'(m) & dirv);
      bus_read(12'h3FC, r);
      check("R3 masked write", r, {24'b0, model});
      bus_read(12'(rm << 2) | 12'(m & 3), r);
      check("R2 masked read", r, {24'b0, model & rm});
      check("R4 pin_o sweep", {24'b0, pout}, {24'b0, model & dirv});
    end

    // synchronizer latency, output pins ignore pin_i
    pin = 8'h3C;
    bus_read(12'h3FC, r);
    check("R5 not yet visible", r, {24'b0, model});
    repeat (3) @(negedge clk);
    model = (model & dirv) | (8'h3C & ~dirv);
    bus_read(12'h3FC, r);
    check("R5 input tracked", r, {24'b0, model});

    for (int k = 0; k < 12; k++) begin
      bus_read(12'hFD0 + 12'(k * 4), r);
      check("R6 id byte", r, {24'b0, id_exp(k)});
    end

    bus_write(12'h404, 32'hFFFF_FFFF);
    bus_write(12'h800, 32'h0);
    bus_write(12'hFD0, 32'hFF);
    bus_read(12'h400, r);
    check("R7 dir untouched", r, {24'b0, dirv});
    bus_read(12'h3FC, r);
    check("R7 data untouched", r, {24'b0, model});
    foreach (r[i]) ;
    begin
      logic [11:0] bad [5] = '{12'h404, 12'h41C, 12'h800, 12'hC00, 12'hFCC};
      for (int j = 0; j < 5; j++) begin
        bus_read(bad[j], r);
        check("R7 unmapped read", r, 0);
      end
    end

    bus_read(12'h400, r);
    held = r[7:0];
    addr = 12'h000;
    repeat (3) @(negedge clk);
    check("R8 rdata holds", rdata, {24'b0, held});
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule